// File: doc/BRIEF.md
# Multichannel DAC Clear-Code Controller

This block is the digital control core of a multichannel digital-to-analog converter. A host writes 32-bit command frames over a three-wire serial link (an active-low frame strobe, a serial clock and a data line). Each channel keeps an input buffer and an output code register. The block decodes a small set of buffer-write commands, a clear-code configuration command and a software reset. All serial and clear inputs are asynchronous to the block clock, and each passes through a two-flop synchronizer before it is used.

An asynchronous active-low clear pin acts on its falling edge. The edge forces every buffer and every output register to the value chosen by a 2-bit clear-code register: zero, midscale or full scale. The fourth code value masks the pin. A clear edge that arrives while a frame is being shifted in discards that frame. After a clear, a status flag stays high until the last serial clock edge of the next complete write frame.

Top module: `dac_clear_ctrl`

## Requirements
- R1: A frame runs only when exactly 32 falling serial-clock edges arrive while the strobe is low. Bits are taken MSB first. The frame runs when the strobe rises. Frames with fewer or more edges change nothing. Field layout: command in bits 27..24, channel address in bits 23..20, data in bits 19..4, feature bits in bits 1..0.
- R2: Command 0000 writes the addressed input buffer only. Command 0011 writes the buffer and the output register of the addressed channel. Command 0010 writes the addressed buffer, then loads every output register from its buffer. Address 1111 selects all channels. Other command codes change no channel.
- R3: Command 0101 loads the clear-code register from feature bits 1..0.
- R4: Clear code 00 gives code zero, 01 gives midscale (only the MSB set) and 10 gives full scale (all ones), at the configured DAC width.
- R5: A falling edge on the clear pin sets every input buffer and every output register to the clear value. Holding the pin low does not clear again.
- R6: A clear sets `clear_mode`. The flag drops at the 32nd falling serial-clock edge of the next frame that is not aborted, before the strobe rises.
- R7: A clear edge while the strobe is low aborts the current frame. That frame makes no register update and does not end clear mode. The clear itself still takes place.
- R8: With clear code 11, falling edges on the clear pin are ignored. Channel values and `clear_mode` do not change.
- R9: Command 0111 (software reset) sets all buffers and output registers to zero and sets the clear-code register back to 00.
- R10: After `rst_n`, all outputs are zero, `clear_mode` is low and the clear code is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_n | input | 1 | Active-low frame strobe (asynchronous) |
| sclk | input | 1 | Serial clock; data is captured on its falling edge (asynchronous) |
| din | input | 1 | Serial data, MSB first |
| clr_n | input | 1 | Active-low clear pin, acts on its falling edge (asynchronous) |
| dac_code | output | NUM_CH*DAC_W | Output code registers, channel 0 in the low bits |
| clear_mode | output | 1 | High from a clear until the end of the next complete frame |

## Verification
The bench targets the exit point of clear mode by pausing a frame after 31 and then after 32 serial edges, with the strobe still low. A design that exits on the strobe rise, or on any frame, fails there. An abort is injected halfway through a frame: a design that still runs the frame leaves its data on the channel, and one that treats it as the next frame drops `clear_mode` too early. The bench holds the clear pin low across a write to catch a level-sensitive clear. It sets code 11 to catch a pin that is not masked. It checks the buffers after a clear, because a design that clears only the output registers would reload stale data on the next update-all command. After a software reset it pulses the clear pin, which shows whether the clear code returned to 00 or stayed masked.

// File: rtl/dac_clear_pkg.sv
package dac_clear_pkg;

  typedef enum logic [3:0] {
    CMD_WR_BUF     = 4'h0,
    CMD_WR_UPD_ALL = 4'h2,
    CMD_WR_LOAD    = 4'h3,
    CMD_CLR_CODE   = 4'h5,
    CMD_SW_RESET   = 4'h7
  } cmd_e;

  typedef enum logic [1:0] {
    CC_ZERO = 2'b00,
    CC_MID  = 2'b01,
    CC_FULL = 2'b10,
    CC_MASK = 2'b11
  } ccode_e;

  localparam int FRAME_BITS = 32;
  localparam int CMD_MSB    = 27;
  localparam int ADDR_MSB   = 23;
  localparam int DATA_MSB   = 19;
  localparam logic [3:0] ADDR_ALL = 4'hF;

  // Clear value for a code at a given DAC width (width at most 16).
  function automatic logic [31:0] clear_value(input logic [1:0] code, input int unsigned width);
    case (code)
      CC_MID:  clear_value = 32'd1 << (width - 1);
      CC_FULL: clear_value = (32'd1 << width) - 32'd1;
      default: clear_value = 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/dac_sync_edge.sv
module dac_sync_edge #(
  parameter int   STAGES    = 2,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int PIPE_W = STAGES + 1;

  logic [PIPE_W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {PIPE_W{IDLE_LEVEL}};
    else        pipe_q <= {pipe_q[PIPE_W-2:0], async_in};
  end

  assign level = pipe_q[STAGES-1];
  assign rise  =  level & ~pipe_q[STAGES];
  assign fall  = ~level &  pipe_q[STAGES];

  a_r5_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sync_low,
  input  logic                  sync_start,
  input  logic                  sync_end,
  input  logic                  sclk_fall,
  input  logic                  din_bit,
  input  logic                  abort_req,
  output logic                  frame_valid,
  output logic [FRAME_BITS-1:0] frame_word,
  output logic                  last_edge,
  output logic                  aborted
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] shreg_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  shift_en;

  assign shift_en  = sync_low && sclk_fall;
  assign last_edge = shift_en && (cnt_q == CNT_LAST) && !aborted && !abort_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q     <= '0;
      cnt_q       <= '0;
      aborted     <= 1'b0;
      frame_valid <= 1'b0;
      frame_word  <= '0;
    end else begin
      frame_valid <= 1'b0;
      if (sync_start) begin
        shreg_q <= '0;
        cnt_q   <= '0;
        aborted <= 1'b0;
      end else begin
        if (shift_en) begin
          shreg_q <= {shreg_q[FRAME_BITS-2:0], din_bit};
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        if (abort_req) aborted <= 1'b1;
        if (sync_end && (cnt_q == CNT_FULL) && !aborted && !abort_req) begin
          frame_valid <= 1'b1;
          frame_word  <= shreg_q;
        end
      end
    end
  end

  a_r7_no_run_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> !aborted);
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  a_r1_valid_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank
  import dac_clear_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DAC_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_evt,
  input  logic [DAC_W-1:0]        clr_val,
  input  logic                    sw_rst,
  input  logic                    wr_en,
  input  cmd_e                    wr_cmd,
  input  logic [3:0]              wr_addr,
  input  logic [DAC_W-1:0]        wr_data,
  output logic [NUM_CH*DAC_W-1:0] dac_flat
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [DAC_W-1:0] hold_q;
    logic [DAC_W-1:0] out_q;
    logic             sel;

    assign sel = (wr_addr == 4'(ch)) || (wr_addr == ADDR_ALL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
        out_q  <= '0;
      end else if (clr_evt) begin
        hold_q <= clr_val;
        out_q  <= clr_val;
      end else if (sw_rst) begin
        hold_q <= '0;
        out_q  <= '0;
      end else if (wr_en) begin
        case (wr_cmd)
          CMD_WR_BUF: begin
            if (sel) hold_q <= wr_data;
          end
          CMD_WR_LOAD: begin
            if (sel) begin
              hold_q <= wr_data;
              out_q  <= wr_data;
            end
          end
          CMD_WR_UPD_ALL: begin
            if (sel) begin
              hold_q <= wr_data;
              out_q  <= wr_data;
            end else begin
              out_q  <= hold_q;
            end
          end
          default: ;
        endcase
      end
    end

    assign dac_flat[ch*DAC_W +: DAC_W] = out_q;

    a_r5_clear_loads_channel: assert property (@(posedge clk) disable iff (!rst_n)
      clr_evt |=> (out_q == $past(clr_val)) && (hold_q == $past(clr_val)));
    a_r9_reset_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rst && !clr_evt) |=> (out_q == '0) && (hold_q == '0));
  end

endmodule

// File: rtl/dac_clear_ctrl.sv
module dac_clear_ctrl
  import dac_clear_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int DAC_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_n,
  input  logic                    sclk,
  input  logic                    din,
  input  logic                    clr_n,
  output logic [NUM_CH*DAC_W-1:0] dac_code,
  output logic                    clear_mode
);
  localparam int N_IN = 4;
  localparam logic [N_IN-1:0] IDLE_LEVELS = 4'b1011; // clr_n, din, sclk, sync_n
  localparam int I_SYNC = 0;
  localparam int I_SCLK = 1;
  localparam int I_DIN  = 2;
  localparam int I_CLR  = 3;

  logic [N_IN-1:0] raw_in, lvl, rise, fall;
  assign raw_in = {clr_n, din, sclk, sync_n};

  for (genvar k = 0; k < N_IN; k++) begin : g_sync
    dac_sync_edge #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(IDLE_LEVELS[k])) i_sync (
      .clk(clk), .rst_n(rst_n), .async_in(raw_in[k]),
      .level(lvl[k]), .rise(rise[k]), .fall(fall[k]));
  end

  logic unused_edges;
  assign unused_edges = ^{rise[I_CLR], rise[I_DIN], rise[I_SCLK], fall[I_DIN], lvl[I_CLR], lvl[I_SCLK]};

  // Named internal events
  logic                  sync_low, clr_fall, clr_evt, abort_req;
  logic                  frame_valid, last_edge, aborted;
  logic [FRAME_BITS-1:0] frame_word;
  logic [1:0]            clr_code_q;
  cmd_e                  cmd;
  logic [3:0]            addr;
  logic [DAC_W-1:0]      data, clr_val;
  logic                  sw_rst, code_wr;

  assign sync_low  = ~lvl[I_SYNC];
  assign clr_fall  = fall[I_CLR];
  assign clr_evt   = clr_fall && (clr_code_q != CC_MASK);
  assign abort_req = clr_evt && sync_low;

  dac_frame_rx #(.FRAME_BITS(FRAME_BITS)) i_rx (
    .clk(clk), .rst_n(rst_n),
    .sync_low(sync_low), .sync_start(fall[I_SYNC]), .sync_end(rise[I_SYNC]),
    .sclk_fall(fall[I_SCLK]), .din_bit(lvl[I_DIN]), .abort_req(abort_req),
    .frame_valid(frame_valid), .frame_word(frame_word),
    .last_edge(last_edge), .aborted(aborted));

  assign cmd     = cmd_e'(frame_word[CMD_MSB -: 4]);
  assign addr    = frame_word[ADDR_MSB -: 4];
  assign data    = frame_word[DATA_MSB -: DAC_W];
  assign sw_rst  = frame_valid && (cmd == CMD_SW_RESET);
  assign code_wr = frame_valid && (cmd == CMD_CLR_CODE);
  assign clr_val = DAC_W'(clear_value(clr_code_q, DAC_W));

  logic unused_frame;
  assign unused_frame = ^{frame_word[FRAME_BITS-1:CMD_MSB+1], frame_word[3:2], aborted};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       clr_code_q <= CC_ZERO;
    else if (sw_rst)  clr_code_q <= CC_ZERO;
    else if (code_wr) clr_code_q <= frame_word[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         clear_mode <= 1'b0;
    else if (clr_evt)   clear_mode <= 1'b1;
    else if (last_edge) clear_mode <= 1'b0;
  end

  dac_chan_bank #(.NUM_CH(NUM_CH), .DAC_W(DAC_W)) i_bank (
    .clk(clk), .rst_n(rst_n), .clr_evt(clr_evt), .clr_val(clr_val),
    .sw_rst(sw_rst), .wr_en(frame_valid), .wr_cmd(cmd), .wr_addr(addr),
    .wr_data(data), .dac_flat(dac_code));

  a_r6_clear_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> clear_mode);
  a_r6_exit_on_last_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clear_mode) |-> $past(last_edge));
  a_r8_masked_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fall && (clr_code_q == CC_MASK) && !frame_valid && !last_edge)
      |=> $stable(dac_code) && $stable(clear_mode));
  a_r3_code_written: assert property (@(posedge clk) disable iff (!rst_n)
    code_wr |=> (clr_code_q == $past(frame_word[1:0])));
  a_r9_code_reset: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (clr_code_q == CC_ZERO));

endmodule

// File: tb/test_dac_clear_ctrl.sv
module test_dac_clear_ctrl;
  localparam int NUM_CH = 8;
  localparam int DAC_W  = 16;
  localparam int NVEC   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1, sclk = 1'b1, din = 1'b0, clr_n = 1'b1;
  logic [NUM_CH*DAC_W-1:0] dac_code;
  logic clear_mode;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dac_clear_ctrl #(.NUM_CH(NUM_CH), .DAC_W(DAC_W)) i_dac_clear_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .din(din),
    .clr_n(clr_n), .dac_code(dac_code), .clear_mode(clear_mode));

  // {frame word, channel to check, expected code}
  localparam logic [55:0] VEC [0:NVEC-1] = '{
    {32'h03012340, 8'd0, 16'h1234},  // R2 write+load ch0
    {32'h037BEEF0, 8'd7, 16'hBEEF},  // R2 write+load ch7
    {32'h00144440, 8'd1, 16'h0000},  // R2 buffer only, output unchanged
    {32'h02222220, 8'd1, 16'h4444},  // R2 update all loads ch1 from its buffer
    {32'h00F0F0F0, 8'd5, 16'h0000},  // R2 broadcast buffer write
    {32'h03555550, 8'd5, 16'h5555},
    {32'h02666660, 8'd3, 16'h0F0F},  // R2 broadcast buffer reaches output
    {32'h03FA5A50, 8'd4, 16'hA5A5},  // R2 broadcast write+load
    {32'h0E099990, 8'd0, 16'hA5A5}   // R2 unknown command ignored
  };

  function automatic logic [DAC_W-1:0] ch_val(input int c);
    return dac_code[c*DAC_W +: DAC_W];
  endfunction

  function automatic logic [31:0] mkw(input logic [3:0] c, input logic [3:0] a,
                                      input logic [15:0] d, input logic [1:0] f);
    return {4'h0, c, a, d, 2'b00, f};
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [15:0] exp);
    for (int c = 0; c < NUM_CH; c++) chk(req, 32'(ch_val(c)), 32'(exp));
  endtask

  task automatic frame_start();
    sync_n = 1'b0; waitc(4);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int first, input int n);
    for (int i = 0; i < n; i++) begin
      din = w[31-first-i]; waitc(4);
      sclk = 1'b0; waitc(4);
      sclk = 1'b1;
    end
  endtask

  task automatic frame_end();
    waitc(4); sync_n = 1'b1; waitc(10);
  endtask

  task automatic send(input logic [31:0] w);
    frame_start(); shift_bits(w, 0, 32); frame_end();
  endtask

  task automatic pulse_clr();
    clr_n = 1'b0; waitc(6); clr_n = 1'b1; waitc(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitc(5); rst_n = 1'b1; waitc(5);
    // R10 reset state
    chk_all("R10 reset code", 16'h0000);
    chk("R10 reset clear_mode", 32'(clear_mode), 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      send(VEC[v][55:24]);
      chk("R2 vector", 32'(ch_val(int'(VEC[v][23:16]))), 32'(VEC[v][15:0]));
    end

    // R5 R4: clear with code 00 gives zero everywhere
    pulse_clr();
    chk_all("R5 clear to zero", 16'h0000);
    chk("R6 mode set", 32'(clear_mode), 32'd1);

    // R6: exit exactly at 32nd edge, before strobe rises
    frame_start(); shift_bits(32'h03013570, 0, 31); waitc(6);
    chk("R6 still in clear after 31 edges", 32'(clear_mode), 32'd1);
    shift_bits(32'h03013570, 31, 1); waitc(6);
    chk("R6 exit at 32nd edge", 32'(clear_mode), 32'd0);
    frame_end();
    chk("R1 frame executed", 32'(ch_val(0)), 32'h1357);

    // R3 R4 midscale, and buffers cleared (R5)
    send(mkw(4'h5, 4'h0, 16'h0, 2'b01));
    pulse_clr();
    chk_all("R4 midscale", 16'h8000);
    send(mkw(4'h2, 4'h1, 16'h0001, 2'b00));
    chk("R5 buffer cleared", 32'(ch_val(0)), 32'h8000);
    chk("R2 update-all data", 32'(ch_val(1)), 32'h0001);

    // R4 full scale
    send(mkw(4'h5, 4'h0, 16'h0, 2'b10));
    pulse_clr();
    chk_all("R4 full scale", 16'hFFFF);

    // R7 abort mid-frame
    send(mkw(4'h3, 4'h2, 16'h1111, 2'b00));
    chk("R6 full frame exits", 32'(clear_mode), 32'd0);
    frame_start(); shift_bits(32'h03233330, 0, 16);
    pulse_clr();
    shift_bits(32'h03233330, 16, 16); frame_end();
    chk("R7 aborted frame dropped", 32'(ch_val(2)), 32'hFFFF);
    chk("R7 aborted frame keeps clear mode", 32'(clear_mode), 32'd1);
    send(mkw(4'h3, 4'h3, 16'h4444, 2'b00));
    chk("R7 next full frame exits", 32'(clear_mode), 32'd0);
    chk("R7 next frame runs", 32'(ch_val(3)), 32'h4444);

    // R5 level held low does not re-clear
    clr_n = 1'b0; waitc(10);
    chk("R5 clear on fall", 32'(ch_val(3)), 32'hFFFF);
    send(mkw(4'h3, 4'h0, 16'h2468, 2'b00));
    chk("R5 no retrigger while low", 32'(ch_val(0)), 32'h2468);
    chk("R5 mode dropped while low", 32'(clear_mode), 32'd0);
    clr_n = 1'b1; waitc(10);
    chk("R5 release no effect", 32'(ch_val(0)), 32'h2468);

    // R8 mask
    send(mkw(4'h5, 4'h0, 16'h0, 2'b11));
    pulse_clr();
    chk("R8 masked value", 32'(ch_val(0)), 32'h2468);
    chk("R8 masked mode", 32'(clear_mode), 32'd0);

    // R9 software reset
    send(32'h07000000);
    chk_all("R9 reset zeroes", 16'h0000);
    send(mkw(4'h3, 4'h1, 16'h7777, 2'b00));
    pulse_clr();
    chk("R9 code back to 00 value", 32'(ch_val(1)), 32'h0000);
    chk("R9 pin unmasked", 32'(clear_mode), 32'd1);

    // R1 short and long frames
    frame_start(); shift_bits(32'h03412120, 0, 31); frame_end();
    chk("R1 short frame dropped", 32'(ch_val(4)), 32'h0000);
    frame_start(); shift_bits(32'h03412120, 0, 32); shift_bits(32'h0, 0, 1); frame_end();
    chk("R1 long frame dropped", 32'(ch_val(4)), 32'h0000);
    send(32'h03412120);
    chk("R1 exact frame", 32'(ch_val(4)), 32'h1212);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule